// File: doc/BRIEF.md
# Request Packetizer with Header Beat

The block turns one request into one packet on a 64-bit valid/ready transmit stream. A one-cycle `start` pulse captures the request fields: transaction ID, transaction kind codes, priority, a CRF flag, byte count, target address and destination ID. The block then sends a header beat built from those fields. After the header, it sends the payload words that a separate source offers on its own valid/ready port.

Both stream interfaces follow valid/ready rules. A beat moves only on a cycle where valid and ready are both high. While valid is high and ready is low, the sender holds data, last and user unchanged. The sink may stall at any time, including the cycle that follows the header and the cycle after a source gap, and the block loses and repeats no word. `pl_ready` is the only back-pressure that reaches the payload source. It is high only during the payload phase, and only when the output stage is empty or its beat leaves on that cycle. `start`, the request fields and the reset stay plain level inputs.

Top module: `req_packetizer`

## Requirements
- R1: The first beat of each packet is the header: [63:56] transaction ID, [55:52] kind code A, [51:48] kind code B, [47] zero, [46:45] priority, [44] CRF, [43:36] size, [35:34] zero, [33:0] address. All fields are captured on the cycle `start` is accepted.
- R2: The size field holds the payload byte count minus one (0..255). The packet carries floor(size/8)+1 payload beats after the header.
- R3: `tx_tkeep` is 8'hFF on every cycle where `tx_tvalid` is high.
- R4: While `tx_tvalid` is high and `tx_tready` is low, on the next cycle `tx_tvalid` stays high and `tx_tdata`, `tx_tlast` and `tx_tuser` are unchanged.
- R5: `tx_tlast` is high on the final payload beat only. It is never high on the header.
- R6: `tx_tuser` equals the captured destination ID on every beat of the packet.
- R7: The payload words appear on `tx_tdata` in source order, each exactly once. This holds under sink stalls, including a stall right after the header, and under source gaps.
- R8: When the payload source keeps its valid high, `tx_tvalid` does not drop between the header and the last beat.
- R9: A `start` pulse while a packet is in progress is ignored. After the last beat is accepted, `tx_tvalid` and `pl_ready` stay low until the next `start`.
- R10: The active-high synchronous reset `rst` puts the block in idle with `tx_tvalid` and `pl_ready` low, even in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, taken only when idle |
| req_tid | input | 8 | Transaction ID |
| req_ftype | input | 4 | Transaction kind code A |
| req_ttype | input | 4 | Transaction kind code B |
| req_prio | input | 2 | Priority |
| req_crf | input | 1 | Critical request flag |
| req_size | input | 8 | Payload bytes minus one |
| req_addr | input | 34 | Target address |
| req_dest | input | 32 | Destination ID, driven on tuser |
| pl_valid | input | 1 | Payload source valid |
| pl_data | input | 64 | Payload word |
| pl_ready | output | 1 | Payload word taken this cycle when high with pl_valid |
| tx_tvalid | output | 1 | Transmit beat valid |
| tx_tready | input | 1 | Sink ready |
| tx_tdata | output | 64 | Header or payload beat |
| tx_tkeep | output | 8 | Byte enables, all ones |
| tx_tlast | output | 1 | Final payload beat |
| tx_tuser | output | 32 | Destination ID |

## Verification
A wrong beat counter shows up on `tx_tlast` of the same packet. The packet ends early or late, so the beat count at the last handshake differs from the header's size field. A bad load enable in the output hold register shows up within one stalled cycle, as a changed `tx_tdata` under a low `tx_tready` or as a repeated or missing word in the payload order. A sequencer state that fails to return to idle shows up as a missing header on the next request. A state that accepts `start` too early shows up as a header in the middle of a packet.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int TID_W   = 8;
  localparam int KIND_W  = 4;
  localparam int PRIO_W  = 2;
  localparam int SIZE_W  = 8;
  localparam int ADDR_W  = 34;
  localparam int ID_W    = 32;
  localparam int WORD_W  = 64;
  localparam int KEEP_W  = WORD_W / 8;
  localparam int BYTE_SH = $clog2(KEEP_W);
  localparam int CNT_W   = $clog2((2 ** SIZE_W) / KEEP_W + 1);

  typedef struct packed {
    logic [TID_W-1:0]  tid;
    logic [KIND_W-1:0] kind_a;
    logic [KIND_W-1:0] kind_b;
    logic [PRIO_W-1:0] prio;
    logic              crf;
    logic [SIZE_W-1:0] size;
    logic [ADDR_W-1:0] addr;
    logic [ID_W-1:0]   dest;
  } pkt_req_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HDR   = 2'd1,
    ST_BODY  = 2'd2,
    ST_DRAIN = 2'd3
  } seq_st_e;
endpackage

// File: rtl/pkt_hdr_fmt.sv
module pkt_hdr_fmt
  import pkt_pkg::*;
(
  input  pkt_req_t          req,
  output logic [WORD_W-1:0] hdr
);
  // Upper byte ID, then kind codes, flags, size, then address in the low bits.
  always_comb begin
    hdr = {req.tid, req.kind_a, req.kind_b, 1'b0, req.prio, req.crf,
           req.size, 2'b00, req.addr};
  end
endmodule

// File: rtl/pkt_hold_reg.sv
module pkt_hold_reg #(
  parameter int W  = 64,
  parameter int UW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic          in_last,
  input  logic [UW-1:0] in_user,
  output logic          in_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          out_last,
  output logic [UW-1:0] out_user,
  input  logic          out_ready
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_user  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (load) begin
        out_data <= in_data;
        out_last <= in_last;
        out_user <= in_user;
      end
    end
  end
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
  import pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  pkt_req_t          req_in,
  input  logic              pl_valid,
  input  logic [WORD_W-1:0] pl_data,
  output logic              pl_ready,
  input  logic              st_ready,
  input  logic              tx_last_fire,
  output logic              st_valid,
  output logic [WORD_W-1:0] st_data,
  output logic              st_last,
  output logic [ID_W-1:0]   st_user
);
  seq_st_e           st;
  pkt_req_t          req_q;
  logic [CNT_W-1:0]  rem;
  logic [CNT_W-1:0]  beats;
  logic [WORD_W-1:0] hdr;

  pkt_hdr_fmt u_hdr (.req(req_q), .hdr(hdr));

  assign beats   = CNT_W'(req_q.size >> BYTE_SH) + CNT_W'(1);
  assign st_user = req_q.dest;

  always_comb begin
    st_valid = 1'b0;
    st_data  = hdr;
    st_last  = 1'b0;
    pl_ready = 1'b0;
    case (st)
      ST_HDR: st_valid = 1'b1;
      ST_BODY: begin
        st_valid = pl_valid;
        st_data  = pl_data;
        st_last  = (rem == CNT_W'(1));
        pl_ready = st_ready;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      req_q <= '0;
      rem   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          req_q <= req_in;
          st    <= ST_HDR;
        end
        ST_HDR: if (st_ready) begin
          rem <= beats;
          st  <= ST_BODY;
        end
        ST_BODY: if (pl_valid && st_ready) begin
          rem <= rem - CNT_W'(1);
          if (rem == CNT_W'(1)) st <= ST_DRAIN;
        end
        ST_DRAIN: if (tx_last_fire) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/req_packetizer.sv
module req_packetizer
  import pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [KIND_W-1:0] req_ftype,
  input  logic [KIND_W-1:0] req_ttype,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic              req_crf,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_dest,
  input  logic              pl_valid,
  input  logic [WORD_W-1:0] pl_data,
  output logic              pl_ready,
  output logic              tx_tvalid,
  input  logic              tx_tready,
  output logic [WORD_W-1:0] tx_tdata,
  output logic [KEEP_W-1:0] tx_tkeep,
  output logic              tx_tlast,
  output logic [ID_W-1:0]   tx_tuser
);
  pkt_req_t          req;
  logic              st_valid, st_ready, st_last;
  logic [WORD_W-1:0] st_data;
  logic [ID_W-1:0]   st_user;

  always_comb begin
    req.tid    = req_tid;
    req.kind_a = req_ftype;
    req.kind_b = req_ttype;
    req.prio   = req_prio;
    req.crf    = req_crf;
    req.size   = req_size;
    req.addr   = req_addr;
    req.dest   = req_dest;
  end

  pkt_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .req_in(req),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
    .st_ready(st_ready), .tx_last_fire(tx_tvalid && tx_tready && tx_tlast),
    .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_user(st_user)
  );

  pkt_hold_reg #(.W(WORD_W), .UW(ID_W)) u_hold (
    .clk(clk), .rst(rst),
    .in_valid(st_valid), .in_data(st_data), .in_last(st_last), .in_user(st_user),
    .in_ready(st_ready),
    .out_valid(tx_tvalid), .out_data(tx_tdata), .out_last(tx_tlast),
    .out_user(tx_tuser), .out_ready(tx_tready)
  );

  assign tx_tkeep = '1;
endmodule

// File: rtl/req_packetizer_chk.sv
module req_packetizer_chk
  import pkt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tx_tvalid,
  input logic              tx_tready,
  input logic [WORD_W-1:0] tx_tdata,
  input logic [KEEP_W-1:0] tx_tkeep,
  input logic              tx_tlast,
  input logic [ID_W-1:0]   tx_tuser,
  input logic              pl_ready
);
  logic              in_pkt;
  logic [CNT_W-1:0]  seen;
  logic [SIZE_W-1:0] sz;
  logic              fire;

  assign fire = tx_tvalid && tx_tready;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt <= 1'b0;
      seen   <= '0;
      sz     <= '0;
    end else if (fire) begin
      if (!in_pkt) begin
        in_pkt <= 1'b1;
        seen   <= '0;
        sz     <= tx_tdata[43:36];
      end else begin
        seen <= seen + CNT_W'(1);
        if (tx_tlast) in_pkt <= 1'b0;
      end
    end
  end

  a_r3_keep_full: assert property (@(posedge clk) disable iff (rst)
    tx_tvalid |-> (tx_tkeep == {KEEP_W{1'b1}}));

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (tx_tvalid && !tx_tready) |=> (tx_tvalid && $stable(tx_tdata) &&
                                   $stable(tx_tlast) && $stable(tx_tuser)));

  a_r5_no_last_on_header: assert property (@(posedge clk) disable iff (rst)
    (tx_tvalid && !in_pkt) |-> !tx_tlast);

  a_r2_beat_count: assert property (@(posedge clk) disable iff (rst)
    (fire && in_pkt && tx_tlast) |->
      ((seen + CNT_W'(1)) == (CNT_W'(sz >> BYTE_SH) + CNT_W'(1))));

  a_r6_user_steady: assert property (@(posedge clk) disable iff (rst)
    (tx_tvalid && in_pkt) |-> $stable(tx_tuser));

  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (!tx_tvalid && !pl_ready));
endmodule

bind req_packetizer req_packetizer_chk u_chk (
  .clk(clk), .rst(rst), .tx_tvalid(tx_tvalid), .tx_tready(tx_tready),
  .tx_tdata(tx_tdata), .tx_tkeep(tx_tkeep), .tx_tlast(tx_tlast),
  .tx_tuser(tx_tuser), .pl_ready(pl_ready)
);

// File: tb/req_packetizer_tb.sv
`timescale 1ns/1ps
module req_packetizer_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0;
  logic [7:0]  tid = '0;
  logic [3:0]  fa = '0, fb = '0;
  logic [1:0]  prio = '0;
  logic        crf = 1'b0;
  logic [7:0]  size = '0;
  logic [33:0] addr = '0;
  logic [31:0] dest = '0;
  logic        pl_valid = 1'b0, pl_ready;
  logic [63:0] pl_data = '0;
  logic        tv, tr = 1'b0, tl;
  logic [63:0] td;
  logic [7:0]  tk;
  logic [31:0] tu;

  req_packetizer u_dut (
    .clk(clk), .rst(rst), .start(start), .req_tid(tid), .req_ftype(fa),
    .req_ttype(fb), .req_prio(prio), .req_crf(crf), .req_size(size),
    .req_addr(addr), .req_dest(dest), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_ready(pl_ready), .tx_tvalid(tv), .tx_tready(tr), .tx_tdata(td),
    .tx_tkeep(tk), .tx_tlast(tl), .tx_tuser(tu)
  );

  int n_chk = 0, n_fail = 0;
  logic [63:0] words [32];
  logic [63:0] exp_hdr;
  logic [31:0] exp_user;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [63:0] mk_hdr(logic [7:0] t, logic [3:0] a, logic [3:0] b,
      logic [1:0] p, logic c, logic [7:0] s, logic [33:0] ad);
    return {t, a, b, 1'b0, p, c, s, 2'b00, ad};
  endfunction

  task automatic rand_fields();
    tid = 8'($urandom); fa = 4'($urandom); fb = 4'($urandom);
    prio = 2'($urandom); crf = 1'($urandom); addr = {2'($urandom), $urandom};
    dest = $urandom;
  endtask

  // kmode: 0 sink always ready, 1 random, 2 drops ready once after header/gap
  // smode: 0 source always valid, 1 source with random gaps
  task automatic run_pkt(input logic [7:0] sz, input int smode, input int kmode,
                         input bit stray);
    int nb, src_i, beat_i, mid_low, cyc;
    bit done, drop_next, pv, pr;
    logic [63:0] pd;
    logic pl_;
    nb = int'(sz >> 3) + 1;
    for (int i = 0; i < 32; i++) words[i] = {$urandom, $urandom};
    rand_fields(); size = sz;
    exp_hdr = mk_hdr(tid, fa, fb, prio, crf, sz, addr);
    exp_user = dest;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; rand_fields(); size = 8'($urandom);
    src_i = 0; beat_i = 0; mid_low = 0; cyc = 0; done = 0; drop_next = 0;
    pv = 0; pr = 0; pd = '0; pl_ = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      tr = (kmode == 0) ? 1'b1 : (kmode == 1) ? ($urandom % 10 < 6) : !drop_next;
      pl_valid = (src_i < nb) && (smode == 0 || ($urandom % 3 != 0));
      pl_data = (src_i < nb) ? words[src_i] : 64'hDEAD;
      start = stray && (cyc == 4);
      if (start) rand_fields();
      #1;
      drop_next = 0;
      if (pv && !pr)
        chk(tv && td == pd && tl == pl_, "R4", "held beat under stall", td, pd);
      if (tv) chk(tk == 8'hFF, "R3", "keep", 64'(tk), 64'hFF);
      if (beat_i > 0 && !tv) begin
        mid_low++;
        drop_next = (kmode == 2);
      end
      if (tv && tr) begin
        if (beat_i == 0) begin
          chk(td == exp_hdr, "R1", "header", td, exp_hdr);
          chk(!tl, "R5", "last on header", 64'(tl), 64'd0);
          drop_next = (kmode == 2);
        end else begin
          chk(td == words[beat_i-1], "R7", "payload order", td, words[beat_i-1]);
          chk(tl == (beat_i == nb), "R5", "last flag", 64'(tl), 64'(beat_i == nb));
        end
        chk(tu == exp_user, "R6", "tuser", 64'(tu), 64'(exp_user));
        beat_i++;
        if (tl) begin
          done = 1;
          chk(beat_i - 1 == nb, "R2", "payload beat count", 64'(beat_i - 1), 64'(nb));
        end
      end
      if (pl_valid && pl_ready) src_i++;
      pv = tv; pr = tr; pd = td; pl_ = tl;
    end
    chk(done, "R7", "packet completed", 64'(done), 64'd1);
    if (smode == 0) chk(mid_low == 0, "R8", "tvalid gaps mid-packet", 64'(mid_low), 64'd0);
    @(negedge clk); start = 1'b0; pl_valid = 1'b0; tr = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!tv && !pl_ready, "R9", "idle after packet", 64'({tv, pl_ready}), 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(!tv && !pl_ready, "R10", "reset state", 64'({tv, pl_ready}), 64'd0);
    @(negedge clk); rst = 1'b0;
    run_pkt(8'd0, 0, 0, 0);
    run_pkt(8'd255, 0, 2, 0);
    run_pkt(8'd7, 1, 2, 0);
    run_pkt(8'd8, 1, 1, 1);
    run_pkt(8'd15, 0, 0, 1);
    // mid-packet reset
    rand_fields(); size = 8'd40;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; tr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    chk(!tv && !pl_ready, "R10", "reset mid-packet", 64'({tv, pl_ready}), 64'd0);
    for (int k = 0; k < 25; k++)
      run_pkt(8'($urandom), int'($urandom % 2), int'($urandom % 3), 1'($urandom));
    summary();
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      summary();
    end
  end
endmodule